// File: doc/BRIEF.md
# Pipelined Full-Word Multiplier with Shift Use

This block multiplies two operand words and returns the complete double-width product as two output words: the lower half and the upper half. A per-operation select bit says whether the operands are two's-complement signed numbers or plain unsigned numbers. The datapath is pipelined, so it accepts a new operation on every clock. Each result appears a fixed number of cycles after its operation is issued, and a valid flag travels alongside it.

When one operand is a power of two, 2^n, the block also works as a barrel shifter. The lower output word holds the other operand shifted left by n. The upper output word holds the other operand shifted right by WIDTH minus n, with zeros shifted in when the select bit says unsigned.

A build-time parameter chooses between one pipeline lane and two lanes used in turn. In the two-lane form, a toggle steers successive operations to alternate lanes, so each lane sees at most one operation every two cycles. An output selector then returns the results in their issue order, and the latency is the same as in the single-lane form.

Top module: `wide_mul`

## Requirements
- R1: With `in_signed` = 0, the operands are read as unsigned. `out_lo` is bits [WIDTH-1:0] and `out_hi` is bits [2*WIDTH-1:WIDTH] of the exact 2*WIDTH-bit product.
- R2: With `in_signed` = 1, the operands are read as two's complement. `{out_hi, out_lo}` is the exact two's-complement 2*WIDTH-bit product, for example (-1)*(-1) = 1 and MIN*MIN = 2^(2*WIDTH-2).
- R3: An operation sampled with `in_valid` = 1 at a rising edge has its result shown, with `out_valid` = 1, right after the LATENCY-th rising edge, counting that edge as the first. `out_valid` is never high at any other time.
- R4: An operation can be issued on every cycle. Back-to-back operations produce results on back-to-back cycles, each with its own correct value.
- R5: In the two-lane form (FORM = FORM_PINGPONG), results have the same latency, issue order and values as in the single-lane form.
- R6: Whenever `out_valid` is 0, `out_lo` and `out_hi` are both zero.
- R7: A rising edge with `rst` = 1 discards every operation in flight. `out_valid` is 0 after that edge, and it is still 0 on the first cycle after `rst` is released.
- R8: Multiplying an operand X by 2^n with `in_signed` = 0 gives `out_lo` = X shifted left by n and `out_hi` = X shifted right by WIDTH-n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result present on this cycle |
| out_lo | output | WIDTH | Lower word of the product |
| out_hi | output | WIDTH | Upper word of the product |

## Verification
The assertions assume that `rst` is held for at least LATENCY cycles at start-up before any result is relied on. They also assume that operands and the sign select are stable around the sampling edge, because the shadow valid and zero-operand tracking in the checker samples them on the same edge as the design. The stimulus drives every input on the falling clock edge and holds reset for several cycles at the start. It also drops `in_valid` at random so that gaps mix with back-to-back runs, and it exercises both the single-lane and the two-lane form at once.

// File: rtl/wm_pkg.sv
package wm_pkg;

    localparam int DEFAULT_WIDTH   = 36;
    localparam int DEFAULT_LATENCY = 3;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mul_mode_e;

    typedef enum logic {
        FORM_SINGLE   = 1'b0,
        FORM_PINGPONG = 1'b1
    } pipe_form_e;

    // Number of parallel lanes implied by a pipeline form.
    function automatic int lanes_for(input pipe_form_e form);
        return (form == FORM_PINGPONG) ? 2 : 1;
    endfunction

endpackage

// File: rtl/wm_extend.sv
module wm_extend #(
    parameter int WIDTH = wm_pkg::DEFAULT_WIDTH,
    localparam int W2   = 2 * WIDTH
) (
    input  wm_pkg::mul_mode_e mode,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    output logic [W2-1:0]     a_ext,
    output logic [W2-1:0]     b_ext
);
    logic fill_a, fill_b;

    // Signed: copy the top bit upward. Unsigned: fill with zeros.
    assign fill_a = (mode == wm_pkg::MODE_SIGNED) & a[WIDTH-1];
    assign fill_b = (mode == wm_pkg::MODE_SIGNED) & b[WIDTH-1];
    assign a_ext  = {{WIDTH{fill_a}}, a};
    assign b_ext  = {{WIDTH{fill_b}}, b};
endmodule

// File: rtl/wm_lane.sv
module wm_lane #(
    parameter int WIDTH   = wm_pkg::DEFAULT_WIDTH,
    parameter int LATENCY = wm_pkg::DEFAULT_LATENCY,
    localparam int W2     = 2 * WIDTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W2-1:0] a_ext,
    input  logic [W2-1:0] b_ext,
    output logic          out_valid,
    output logic [W2-1:0] out_prod
);
    // Stage 0 registers the extended operands and stage 1 the product.
    // The remaining stages only delay the product.
    logic [LATENCY-1:0]         vld_q;
    logic [W2-1:0]              opa_q, opb_q;
    logic [LATENCY-1:1][W2-1:0] prod_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[LATENCY-2:0], in_valid};
        end
        opa_q     <= a_ext;
        opb_q     <= b_ext;
        prod_q[1] <= opa_q * opb_q;
        for (int s = 2; s < LATENCY; s++) begin
            prod_q[s] <= prod_q[s-1];
        end
    end

    assign out_valid = vld_q[LATENCY-1];
    assign out_prod  = prod_q[LATENCY-1];

    initial begin
        if (LATENCY < 2) $error("wm_lane: LATENCY must be at least 2");
    end
endmodule

// File: rtl/wide_mul.sv
module wide_mul #(
    parameter int                 WIDTH   = wm_pkg::DEFAULT_WIDTH,
    parameter int                 LATENCY = wm_pkg::DEFAULT_LATENCY,
    parameter wm_pkg::pipe_form_e FORM    = wm_pkg::FORM_SINGLE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_signed,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_lo,
    output logic [WIDTH-1:0] out_hi
);
    localparam int W2     = 2 * WIDTH;
    localparam int NLANES = wm_pkg::lanes_for(FORM);

    wm_pkg::mul_mode_e         mode;
    logic [W2-1:0]             a_ext, b_ext;
    logic [NLANES-1:0]         lane_in_vld, lane_out_vld;
    logic [NLANES-1:0][W2-1:0] lane_prod;
    logic [W2-1:0]             picked;

    assign mode = in_signed ? wm_pkg::MODE_SIGNED : wm_pkg::MODE_UNSIGNED;

    wm_extend #(.WIDTH(WIDTH)) u_extend (
        .mode  (mode),
        .a     (in_a),
        .b     (in_b),
        .a_ext (a_ext),
        .b_ext (b_ext)
    );

    generate
        if (NLANES == 2) begin : g_pingpong
            logic turn_q;  // 0: next operation goes to lane 0
            always_ff @(posedge clk) begin
                if (rst)           turn_q <= 1'b0;
                else if (in_valid) turn_q <= ~turn_q;
            end
            assign lane_in_vld = {in_valid & turn_q, in_valid & ~turn_q};
        end else begin : g_single
            assign lane_in_vld = in_valid;
        end

        for (genvar l = 0; l < NLANES; l++) begin : g_lane
            wm_lane #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_lane (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (lane_in_vld[l]),
                .a_ext     (a_ext),
                .b_ext     (b_ext),
                .out_valid (lane_out_vld[l]),
                .out_prod  (lane_prod[l])
            );
        end
    endgenerate

    // At most one lane finishes per cycle because their issue cycles differ.
    always_comb begin
        picked = '0;
        for (int l = 0; l < NLANES; l++) begin
            if (lane_out_vld[l]) picked = lane_prod[l];
        end
    end

    assign out_valid = |lane_out_vld;
    assign out_lo    = picked[WIDTH-1:0];
    assign out_hi    = picked[W2-1:WIDTH];
endmodule

// File: rtl/wide_mul_chk.sv
module wide_mul_chk #(
    parameter int WIDTH   = wm_pkg::DEFAULT_WIDTH,
    parameter int LATENCY = wm_pkg::DEFAULT_LATENCY
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_lo,
    input logic [WIDTH-1:0] out_hi
);
    // Shadow trackers: issue flags and zero-operand flags delayed by LATENCY.
    logic [LATENCY-1:0] sh_vld, sh_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_vld  <= '0;
            sh_zero <= '0;
        end else begin
            sh_vld  <= {sh_vld[LATENCY-2:0], in_valid};
            sh_zero <= {sh_zero[LATENCY-2:0],
                        in_valid && ((in_a == '0) || (in_b == '0))};
        end
    end

    assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid == sh_vld[LATENCY-1]);

    assert_idle_outputs_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_lo == '0 && out_hi == '0));

    assert_flushed_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    assert_zero_operand_product_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sh_zero[LATENCY-1]) |-> (out_lo == '0 && out_hi == '0));
endmodule

bind wide_mul wide_mul_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_lo    (out_lo),
    .out_hi    (out_hi)
);

// File: tb/wide_mul_test.sv
`timescale 1ns/1ps
module wide_mul_test;
    localparam int W    = 36;
    localparam int L    = 3;
    localparam int NTBL = 10;
    localparam int NC   = 170;

    // Row layout: {signed, a, b, expected_hi, expected_lo}
    localparam logic [144:0] TBL [NTBL] = '{
        {1'b0, 36'h000000000, 36'h123456789, 36'h000000000, 36'h000000000},
        {1'b0, 36'h000000001, 36'hABCDEF012, 36'h000000000, 36'hABCDEF012},
        {1'b0, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 36'hFFFFFFFFE, 36'h000000001},
        {1'b1, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 36'h000000000, 36'h000000001},
        {1'b1, 36'h800000000, 36'hFFFFFFFFF, 36'h000000000, 36'h800000000},
        {1'b1, 36'h800000000, 36'h800000000, 36'h400000000, 36'h000000000},
        {1'b0, 36'h123456789, 36'h000000010, 36'h000000001, 36'h234567890},
        {1'b1, 36'hFFFFFFFFE, 36'h000000003, 36'hFFFFFFFFF, 36'hFFFFFFFFA},
        {1'b0, 36'hFFFFFFFFE, 36'h000000003, 36'h000000002, 36'hFFFFFFFFA},
        {1'b0, 36'hF00000000, 36'h000000100, 36'h0000000F0, 36'h000000000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_signed = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0;
    logic         s_valid, p_valid;
    logic [W-1:0] s_lo, s_hi, p_lo, p_hi;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic         hv [NC];
    logic         hs [NC];
    logic [W-1:0] ha [NC], hb [NC], hlo [NC], hhi [NC];
    string        htag [NC];

    always #4 clk = ~clk;

    wide_mul #(.WIDTH(W), .LATENCY(L), .FORM(wm_pkg::FORM_SINGLE)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_signed(in_signed),
        .in_a(in_a), .in_b(in_b), .out_valid(s_valid), .out_lo(s_lo), .out_hi(s_hi));

    wide_mul #(.WIDTH(W), .LATENCY(L), .FORM(wm_pkg::FORM_PINGPONG)) uut_pp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_signed(in_signed),
        .in_a(in_a), .in_b(in_b), .out_valid(p_valid), .out_lo(p_lo), .out_hi(p_hi));

    function automatic logic [2*W-1:0] ref_prod(input logic s, input logic [W-1:0] a,
                                                input logic [W-1:0] b);
        logic signed [2*W-1:0] x, y;
        if (s) begin
            x = $signed(a);
            y = $signed(b);
            return x * y;
        end
        return {{W{1'b0}}, a} * {{W{1'b0}}, b};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_slot(input string nm, input string ptag, input logic v,
                              input logic [W-1:0] lo, input logic [W-1:0] hi, input int k);
        check({nm, " ", ptag, " R3 R4 valid"}, W'(v), W'(hv[k]));
        if (hv[k]) begin
            check({nm, " ", ptag, " ", htag[k], " lo"}, lo, hlo[k]);
            check({nm, " ", ptag, " ", htag[k], " hi"}, hi, hhi[k]);
        end else begin
            check({nm, " R6 idle lo"}, lo, '0);
            check({nm, " R6 idle hi"}, hi, '0);
        end
    endtask

    initial begin
        // Build the stimulus history: table first, then mixed random traffic.
        for (int c = 0; c < NC; c++) begin
            logic [2*W-1:0] p;
            if (c < NTBL) begin
                hv[c]  = 1'b1;
                hs[c]  = TBL[c][144];
                ha[c]  = TBL[c][143:108];
                hb[c]  = TBL[c][107:72];
                hhi[c] = TBL[c][71:36];
                hlo[c] = TBL[c][35:0];
                htag[c] = (c == 6 || c == 9) ? "R8" : (hs[c] ? "R2" : "R1");
            end else begin
                int kind = int'($urandom % 4);
                int n    = int'($urandom % W);
                hv[c] = ($urandom % 5) != 0;
                hs[c] = $urandom % 2;
                ha[c] = W'({$urandom, $urandom});
                hb[c] = W'({$urandom, $urandom});
                htag[c] = hs[c] ? "R2" : "R1";
                if (kind == 1) begin
                    case ($urandom % 4)
                        0: ha[c] = '0;
                        1: ha[c] = W'(1);
                        2: ha[c] = '1;
                        default: ha[c] = {1'b1, {(W-1){1'b0}}};
                    endcase
                end else if (kind == 2) begin
                    hs[c] = 1'b0;
                    hb[c] = W'(1) << n;
                    htag[c] = "R8";
                end
                p = ref_prod(hs[c], ha[c], hb[c]);
                if (htag[c] == "R8") begin
                    // Shift view: left by n in low word, right by W-n in high word.
                    hlo[c] = ha[c] << n;
                    hhi[c] = (n == 0) ? '0 : (ha[c] >> (W - n));
                end else begin
                    hlo[c] = p[W-1:0];
                    hhi[c] = p[2*W-1:W];
                end
            end
        end

        // Reset state (R7).
        repeat (3) @(negedge clk);
        check("uut R7 reset valid", W'(s_valid), '0);
        check("uut_pp R7 reset valid", W'(p_valid), '0);
        check("uut R6 reset lo", s_lo, '0);
        rst = 1'b0;
        @(negedge clk);
        check("uut R7 first cycle after reset", W'(s_valid), '0);

        // Streamed vectors: issue at cycle c, result sampled at cycle c+L.
        for (int c = 0; c < NC + L; c++) begin
            if (c > 0) @(negedge clk);
            if (c >= L) begin
                check_slot("uut", "single", s_valid, s_lo, s_hi, c - L);
                check_slot("uut_pp", "R5", p_valid, p_lo, p_hi, c - L);
            end
            if (c < NC) begin
                in_valid  = hv[c];
                in_signed = hs[c];
                in_a      = ha[c];
                in_b      = hb[c];
            end else begin
                in_valid = 1'b0;
            end
        end

        // Reset while operations are in flight (R7).
        @(negedge clk);
        in_valid = 1'b1; in_signed = 1'b0; in_a = W'(5); in_b = W'(6);
        @(negedge clk);
        in_a = W'(7);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            check("uut R7 flush", W'(s_valid), '0);
            check("uut_pp R7 flush", W'(p_valid), '0);
        end
        rst = 1'b0;
        @(negedge clk);
        check("uut R7 after release", W'(s_valid), '0);
        check("uut_pp R7 after release", W'(p_valid), '0);

        // Fresh operation after the flush.
        in_valid = 1'b1; in_signed = 1'b1; in_a = W'(7); in_b = '1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (L - 1) @(negedge clk);
        check("uut R3 post-reset valid", W'(s_valid), W'(1));
        check("uut R2 post-reset lo", s_lo, 36'hFFFFFFFF9);
        check("uut_pp R5 post-reset hi", p_hi, '1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule